// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block sequences I2C master transfers from a small register set. Software writes the target address byte, a packed pair of byte counts, a transaction count and a few control flags, then writes a launch bit. The sequencer then generates START, the address byte, the data bytes and the acknowledge slots on open-drain clock and data enables. Between transactions it issues either a STOP or a repeated START, and a combined mode turns a write phase into a read phase with no STOP in between.

Outgoing bytes are pulled through a request/valid handshake. Incoming bytes are presented as one-cycle valid pulses. A timing strobe input sets the bus rate, and each bit takes four strobes. Completion and acknowledge-error events set sticky status bits that software clears by writing one to them. A mask register selects which status bits drive the registered interrupt output. A soft-reset register write aborts any transfer at once.

Register word offsets: 0 address byte, 1 length, 2 control, 3 transaction count, 4 launch, 5 status, 6 interrupt mask, 7 soft reset. Registers 0, 1, 2, 3, 5 and 6 read back. Offsets 4 and 7 read as zero.

Top module: `i2c_txn_sequencer`

## Requirements
- R1: After reset, all readable registers read zero, both bus enables are inactive (lines released) and the interrupt output is low.
- R2: The first byte after each START is the address register byte [7:0], sent unchanged outside combined mode. Its bit 0 selects the direction of the transaction, where 1 means read.
- R3: A write transaction sends length bits [7:0] data bytes, MSB first. Each byte is fetched through the tx_req/tx_valid handshake and is followed by an acknowledge slot in which SDA is released.
- R4: A read transaction receives length bits [7:0] bytes, MSB first, and presents each on rx_data with a one-cycle rx_valid. The master drives ACK (SDA low) after every byte except the last, which it answers with NACK (SDA released) before ending the transaction.
- R5: The transaction count register sets how many address+data transactions run. A value of 0 counts as 1. Control bit 1 = 0 puts a STOP between transactions, and control bit 1 = 1 puts a repeated START there. Exactly one STOP ends the sequence.
- R6: Control bit 4 selects combined mode, which always runs exactly two transactions. The first sends the address with bit 0 forced to 0 and writes length[7:0] bytes. A repeated START follows, with no STOP. The second sends the address with bit 0 forced to 1 and reads length[15:8] bytes. A single STOP ends the sequence.
- R7: With control bit 5 = 1, a NACK on any byte the master sends sets status bit 1. No further byte is transferred. The sequencer then issues STOP and only then sets status bit 0.
- R8: With control bit 5 = 0, a NACK is ignored. The transfer runs to its programmed end and status bit 1 stays 0.
- R9: Status bit 0 (done) and bit 1 (ack error) are sticky. Writing 1 to a bit clears only that bit, and writing 0 leaves it unchanged.
- R10: The interrupt output is high exactly when a status bit whose mask bit (register 6, same bit position) is 1 is set. It lags the status by one cycle.
- R11: Writing 1 to bit 0 of the soft-reset register returns the sequencer to idle on the next cycle and releases both lines. The aborted transfer never sets done.
- R12: Outside a transfer both lines are released. While SCL is released, SDA changes only to form a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for reg_addr, one cycle later |
| tick | input | 1 | Bus timing strobe, one quarter bit per pulse |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA line level |
| tx_req | output | 1 | Sequencer waits for the next byte to send |
| tx_valid | input | 1 | tx_data holds the requested byte |
| tx_data | input | 8 | Byte to send |
| rx_valid | output | 1 | One-cycle pulse: rx_data holds a received byte |
| rx_data | output | 8 | Received byte |
| irq | output | 1 | Masked status interrupt |

## Verification
The bench builds the block with its defaults: 3-bit register offsets, 16-bit registers and 8-bit counts, so both byte counts fill the length register exactly. It pulses the timing strobe every second clock, so a full byte with its acknowledge slot takes about 72 clocks. This keeps multi-byte reads, combined transfers and multi-transaction sequences within a few thousand cycles each. A behavioural target on the modelled open-drain lines answers only one address. That lets the same bench reach the acknowledge-error path, with detection on and off, by aiming at a different address.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  // register word offsets
  localparam int OFF_ADDR  = 0;
  localparam int OFF_LEN   = 1;
  localparam int OFF_CTRL  = 2;
  localparam int OFF_TCNT  = 3;
  localparam int OFF_GO    = 4;
  localparam int OFF_STAT  = 5;
  localparam int OFF_MASK  = 6;
  localparam int OFF_SRST  = 7;

  // control bit positions
  localparam int CB_RSTART = 1;
  localparam int CB_DIRCHG = 4;
  localparam int CB_ACKDET = 5;

  // status bit positions
  localparam int STAT_W    = 2;
  localparam int SB_DONE   = 0;
  localparam int SB_ACKERR = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_ACK,
    ST_TXWAIT,
    ST_STOP
  } seq_state_e;

endpackage

// File: rtl/i2cseq_regs.sv
module i2cseq_regs
  import i2cseq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 evt_done,
  input  logic                 evt_ackerr,
  output logic [7:0]           cfg_addr,
  output logic [CNT_W-1:0]     cfg_len1,
  output logic [CNT_W-1:0]     cfg_len2,
  output logic                 cfg_rs,
  output logic                 cfg_dirchg,
  output logic                 cfg_ackdet,
  output logic [CNT_W-1:0]     cfg_tcount,
  output logic                 go,
  output logic                 srst,
  output logic [STAT_W-1:0]    stat,
  output logic [STAT_W-1:0]    mask,
  output logic                 irq
);

  localparam int LEN_W = 2 * CNT_W;

  logic [7:0]        addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              rs_q, dir_q, det_q;
  logic [CNT_W-1:0]  tcnt_q;
  logic [STAT_W-1:0] stat_q, mask_q, set_v, clr_v;
  logic [DATA_W-1:0] ctrl_view;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  assign go   = reg_wr && hit(reg_addr, OFF_GO)   && reg_wdata[0];
  assign srst = reg_wr && hit(reg_addr, OFF_SRST) && reg_wdata[0];

  always_comb begin
    set_v            = '0;
    set_v[SB_DONE]   = evt_done;
    set_v[SB_ACKERR] = evt_ackerr;
    clr_v = (reg_wr && hit(reg_addr, OFF_STAT)) ? reg_wdata[STAT_W-1:0] : '0;
    ctrl_view            = '0;
    ctrl_view[CB_RSTART] = rs_q;
    ctrl_view[CB_DIRCHG] = dir_q;
    ctrl_view[CB_ACKDET] = det_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      len_q     <= '0;
      rs_q      <= 1'b0;
      dir_q     <= 1'b0;
      det_q     <= 1'b0;
      tcnt_q    <= '0;
      stat_q    <= '0;
      mask_q    <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && hit(reg_addr, OFF_ADDR)) addr_q <= reg_wdata[7:0];
      if (reg_wr && hit(reg_addr, OFF_LEN))  len_q  <= reg_wdata[LEN_W-1:0];
      if (reg_wr && hit(reg_addr, OFF_CTRL)) begin
        rs_q  <= reg_wdata[CB_RSTART];
        dir_q <= reg_wdata[CB_DIRCHG];
        det_q <= reg_wdata[CB_ACKDET];
      end
      if (reg_wr && hit(reg_addr, OFF_TCNT)) tcnt_q <= reg_wdata[CNT_W-1:0];
      if (reg_wr && hit(reg_addr, OFF_MASK)) mask_q <= reg_wdata[STAT_W-1:0];
      // a new event wins over a clear in the same cycle
      stat_q <= (stat_q & ~clr_v) | set_v;
      irq    <= |(stat_q & mask_q);
      if      (hit(reg_addr, OFF_ADDR)) reg_rdata <= DATA_W'(addr_q);
      else if (hit(reg_addr, OFF_LEN))  reg_rdata <= DATA_W'(len_q);
      else if (hit(reg_addr, OFF_CTRL)) reg_rdata <= ctrl_view;
      else if (hit(reg_addr, OFF_TCNT)) reg_rdata <= DATA_W'(tcnt_q);
      else if (hit(reg_addr, OFF_STAT)) reg_rdata <= DATA_W'(stat_q);
      else if (hit(reg_addr, OFF_MASK)) reg_rdata <= DATA_W'(mask_q);
      else                              reg_rdata <= '0;
    end
  end

  assign cfg_addr   = addr_q;
  assign cfg_len1   = len_q[CNT_W-1:0];
  assign cfg_len2   = len_q[LEN_W-1:CNT_W];
  assign cfg_rs     = rs_q;
  assign cfg_dirchg = dir_q;
  assign cfg_ackdet = det_q;
  assign cfg_tcount = tcnt_q;
  assign stat       = stat_q;
  assign mask       = mask_q;

endmodule

// File: rtl/i2cseq_engine.sv
module i2cseq_engine
  import i2cseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst,
  input  logic             go,
  input  logic [7:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_len1,
  input  logic [CNT_W-1:0] cfg_len2,
  input  logic             cfg_rs,
  input  logic             cfg_dirchg,
  input  logic             cfg_ackdet,
  input  logic [CNT_W-1:0] cfg_tcount,
  input  logic             tick,
  input  logic             sda_in,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             tx_req,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             evt_done,
  output logic             evt_ackerr,
  output logic             busy,
  output seq_state_e       state_o
);

  seq_state_e       st;
  logic [1:0]       q;        // quarter of the current bit
  logic [2:0]       bitn;
  logic [7:0]       sh;
  logic             in_addr, is_rd, phase, ackbit;
  logic [CNT_W-1:0] bytes_left, txns_left, remain;
  logic             txmode;

  assign txmode = in_addr | ~is_rd;
  assign remain = in_addr ? bytes_left : bytes_left - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      st         <= ST_IDLE;
      q          <= '0;
      bitn       <= '0;
      sh         <= '0;
      in_addr    <= 1'b0;
      is_rd      <= 1'b0;
      phase      <= 1'b0;
      ackbit     <= 1'b0;
      bytes_left <= '0;
      txns_left  <= '0;
      scl_oe     <= 1'b0;
      sda_oe     <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      evt_done   <= 1'b0;
      evt_ackerr <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      evt_done   <= 1'b0;
      evt_ackerr <= 1'b0;
      unique case (st)
        ST_IDLE: if (go) begin
          st        <= ST_START;
          q         <= '0;
          phase     <= 1'b0;
          txns_left <= cfg_dirchg ? CNT_W'(2)
                     : ((cfg_tcount == '0) ? CNT_W'(1) : cfg_tcount);
        end
        ST_START: if (tick) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: begin
              scl_oe     <= 1'b1;
              st         <= ST_BIT;
              bitn       <= 3'd7;
              in_addr    <= 1'b1;
              sh         <= cfg_dirchg ? {cfg_addr[7:1], phase} : cfg_addr;
              is_rd      <= cfg_dirchg ? phase : cfg_addr[0];
              bytes_left <= (cfg_dirchg && phase) ? cfg_len2 : cfg_len1;
            end
          endcase
        end
        ST_BIT: if (tick) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: sda_oe <= txmode ? ~sh[7] : 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sh     <= {sh[6:0], sda_in};
            default: begin
              scl_oe <= 1'b1;
              if (bitn == 3'd0) st <= ST_ACK;
              else              bitn <= bitn - 3'd1;
            end
          endcase
        end
        ST_ACK: if (tick) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: begin
              if (txmode) sda_oe <= 1'b0;
              else begin
                sda_oe   <= (bytes_left != CNT_W'(1));
                rx_valid <= 1'b1;
                rx_data  <= sh;
              end
            end
            2'd1: scl_oe <= 1'b0;
            2'd2: ackbit <= sda_in;
            default: begin
              scl_oe <= 1'b1;
              if (txmode && ackbit && cfg_ackdet) begin
                evt_ackerr <= 1'b1;
                txns_left  <= '0;
                st         <= ST_STOP;
              end else begin
                if (!in_addr) bytes_left <= bytes_left - CNT_W'(1);
                in_addr <= 1'b0;
                if (remain != '0) begin
                  bitn <= 3'd7;
                  st   <= is_rd ? ST_BIT : ST_TXWAIT;
                end else begin
                  txns_left <= txns_left - CNT_W'(1);
                  phase     <= ~phase;
                  if (txns_left == CNT_W'(1) || !(cfg_rs || cfg_dirchg))
                    st <= ST_STOP;
                  else
                    st <= ST_START;
                end
              end
            end
          endcase
        end
        ST_TXWAIT: if (tx_valid) begin
          sh <= tx_data;
          st <= ST_BIT;
        end
        ST_STOP: if (tick) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: begin
              if (txns_left != '0) st <= ST_START;
              else begin
                st       <= ST_IDLE;
                evt_done <= 1'b1;
              end
            end
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign tx_req  = (st == ST_TXWAIT);
  assign busy    = (st != ST_IDLE);
  assign state_o = st;

endmodule

// File: rtl/i2c_txn_sequencer.sv
module i2c_txn_sequencer
  import i2cseq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in,
  output logic              tx_req,
  input  logic              tx_valid,
  input  logic [7:0]        tx_data,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              irq
);

  logic [7:0]        cfg_addr;
  logic [CNT_W-1:0]  cfg_len1, cfg_len2, cfg_tcount;
  logic              cfg_rs, cfg_dirchg, cfg_ackdet;
  logic              go, srst, evt_done, evt_ackerr, busy;
  logic [STAT_W-1:0] stat, mask;
  seq_state_e        eng_st;

  i2cseq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_done(evt_done), .evt_ackerr(evt_ackerr),
    .cfg_addr(cfg_addr), .cfg_len1(cfg_len1), .cfg_len2(cfg_len2),
    .cfg_rs(cfg_rs), .cfg_dirchg(cfg_dirchg), .cfg_ackdet(cfg_ackdet),
    .cfg_tcount(cfg_tcount), .go(go), .srst(srst),
    .stat(stat), .mask(mask), .irq(irq)
  );

  i2cseq_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst), .srst(srst), .go(go),
    .cfg_addr(cfg_addr), .cfg_len1(cfg_len1), .cfg_len2(cfg_len2),
    .cfg_rs(cfg_rs), .cfg_dirchg(cfg_dirchg), .cfg_ackdet(cfg_ackdet),
    .cfg_tcount(cfg_tcount), .tick(tick), .sda_in(sda_in),
    .tx_valid(tx_valid), .tx_data(tx_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .tx_req(tx_req),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .evt_done(evt_done), .evt_ackerr(evt_ackerr),
    .busy(busy), .state_o(eng_st)
  );

endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker
  import i2cseq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              srst,
  input logic              busy,
  input seq_state_e        st,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              tx_req,
  input logic              rx_valid,
  input logic [STAT_W-1:0] stat,
  input logic [STAT_W-1:0] mask,
  input logic              irq
);

  AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe)); // R12

  AST_SDA_ONLY_FRAMES: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && $past(!scl_oe) && !$stable(sda_oe) && !$past(srst))
      |-> ($past(st) == ST_START || $past(st) == ST_STOP)); // R12

  AST_DONE_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[SB_DONE]) |-> $past(!busy)); // R7

  AST_ACKERR_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[SB_ACKERR]) |-> $past(busy)); // R7

  AST_NO_TX_RX_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !tx_req); // R3

  AST_SRST_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    srst |=> (!busy && !scl_oe && !sda_oe)); // R11

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq); // R10

endmodule

bind i2c_txn_sequencer i2cseq_checker u_chk (
  .clk(clk), .rst(rst), .srst(srst), .busy(busy), .st(eng_st),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .tx_req(tx_req), .rx_valid(rx_valid),
  .stat(stat), .mask(mask), .irq(irq)
);

// File: tb/test_i2c_txn_sequencer.sv
module test_i2c_txn_sequencer;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam logic [6:0] TGT = 7'h50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic tick = 1'b0;
  logic scl_oe, sda_oe, sda_in, tx_req, rx_valid, irq;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  i2c_txn_sequencer i_i2c_txn_sequencer (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in),
    .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .irq(irq)
  );

  // open-drain lines
  logic slv_low = 1'b0;
  wire scl_l = !scl_oe;
  wire sda_l = !(sda_oe || slv_low);
  assign sda_in = sda_l;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] txmem [16];
  logic [7:0] rdmem [16];
  logic [7:0] wlog  [16];
  logic [7:0] rlog  [16];
  int wcnt, rcnt, txi, ri, n_start, n_stop, mack_cnt, mnack_cnt;

  // timing strobe every second clock
  logic tdiv = 1'b0;
  always @(negedge clk) begin
    tdiv = ~tdiv;
    tick = tdiv;
  end

  // byte source and sink
  always @(negedge clk) begin
    if (tx_req && !tx_valid) begin
      tx_valid = 1'b1;
      tx_data  = txmem[txi & 15];
      txi++;
    end else tx_valid = 1'b0;
    if (rx_valid) begin
      rlog[rcnt & 15] = rx_data;
      rcnt++;
    end
  end

  // behavioural target answering address TGT
  logic scl_p = 1'b1, sda_p = 1'b1, cur_scl, cur_sda;
  logic aph = 1'b0, srd = 1'b0, matched = 1'b0, sending = 1'b0, mack = 1'b1;
  logic [7:0] tsh = '0, rdb = '0;
  int bc = 0;
  always @(negedge clk) begin
    cur_scl = scl_l;
    cur_sda = sda_l;
    if (scl_p && cur_scl && sda_p && !cur_sda) begin
      n_start++; bc = 0; aph = 1'b1; slv_low = 1'b0; sending = 1'b0;
    end else if (scl_p && cur_scl && !sda_p && cur_sda) begin
      n_stop++; aph = 1'b0; srd = 1'b0; matched = 1'b0; sending = 1'b0; slv_low = 1'b0;
    end else if (!scl_p && cur_scl) begin
      if (bc < 8) tsh = {tsh[6:0], cur_sda};
      else mack = cur_sda;
      bc++;
    end else if (scl_p && !cur_scl) begin
      if (bc == 8) begin
        if (aph) begin
          matched = (tsh[7:1] == TGT);
          srd = tsh[0];
          wlog[wcnt & 15] = tsh; wcnt++;
          slv_low = matched;
        end else if (!srd && matched) begin
          wlog[wcnt & 15] = tsh; wcnt++;
          slv_low = 1'b1;
        end else slv_low = 1'b0;
      end else if (bc == 9) begin
        bc = 0;
        if (aph) begin
          aph = 1'b0;
          if (srd && matched) begin
            rdb = rdmem[ri & 15]; ri++; sending = 1'b1; slv_low = !rdb[7];
          end else slv_low = 1'b0;
        end else if (srd && matched && sending) begin
          if (!mack) begin
            mack_cnt++; rdb = rdmem[ri & 15]; ri++; slv_low = !rdb[7];
          end else begin
            mnack_cnt++; sending = 1'b0; slv_low = 1'b0;
          end
        end else slv_low = 1'b0;
      end else if (bc >= 1 && bc <= 7 && srd && sending && !aph) begin
        slv_low = !rdb[7 - bc];
      end
    end
    scl_p = cur_scl;
    sda_p = cur_sda;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_w(input int a, input int d);
    reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_r(input int a, output int v);
    reg_addr = ADDR_W'(a);
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic clear_logs();
    wcnt = 0; rcnt = 0; txi = 0; ri = 0;
    n_start = 0; n_stop = 0; mack_cnt = 0; mnack_cnt = 0;
  endtask

  task automatic wait_done(output int stat);
    stat = 0;
    for (int i = 0; i < 4000; i++) begin
      reg_r(5, stat);
      if (stat[0]) break;
    end
    @(negedge clk);
  endtask

  task automatic launch(input int addr, input int len, input int ctrl, input int tcnt);
    clear_logs();
    reg_w(0, addr); reg_w(1, len); reg_w(2, ctrl); reg_w(3, tcnt);
    reg_w(4, 1);
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 8; a++) begin
      reg_r(a, v);
      chk("R1 register zero", v, 0);
    end
    chk("R1 scl released", int'(scl_oe), 0);
    chk("R1 sda released", int'(sda_oe), 0);
    chk("R1 irq low", int'(irq), 0);
  endtask

  task automatic t_write();
    int s;
    reg_w(6, 1);
    launch(8'hA0, 2, 8'h20, 1);
    wait_done(s);
    chk("R3 status done", s, 1);
    chk("R2 address byte", int'(wlog[0]), 8'hA0);
    chk("R3 data byte 0", int'(wlog[1]), int'(txmem[0]));
    chk("R3 data byte 1", int'(wlog[2]), int'(txmem[1]));
    chk("R3 bytes fetched", txi, 2);
    chk("R3 bytes on bus", wcnt, 3);
    chk("R12 single start", n_start, 1);
    chk("R12 single stop", n_stop, 1);
    chk("R10 irq on done", int'(irq), 1);
    reg_w(5, 1);
    reg_r(5, s);
    chk("R9 cleared", s, 0);
    chk("R10 irq drops", int'(irq), 0);
  endtask

  task automatic t_read();
    int s;
    launch(8'hA1, 3, 8'h20, 1);
    wait_done(s);
    chk("R4 status done", s, 1);
    chk("R2 read address", int'(wlog[0]), 8'hA1);
    chk("R4 bytes received", rcnt, 3);
    for (int i = 0; i < 3; i++) chk("R4 read data", int'(rlog[i]), int'(rdmem[i]));
    chk("R4 master acks", mack_cnt, 2);
    chk("R4 final nack", mnack_cnt, 1);
    chk("R4 no tx fetch", txi, 0);
    reg_w(5, 3);
  endtask

  task automatic t_combined();
    int s;
    launch(8'hA1, 16'h0201, 8'h32, 5);
    wait_done(s);
    chk("R6 status done", s, 1);
    chk("R6 starts", n_start, 2);
    chk("R6 stops", n_stop, 1);
    chk("R6 write address", int'(wlog[0]), 8'hA0);
    chk("R6 write data", int'(wlog[1]), int'(txmem[0]));
    chk("R6 read address", int'(wlog[2]), 8'hA1);
    chk("R6 read count", rcnt, 2);
    chk("R6 read data 0", int'(rlog[0]), int'(rdmem[0]));
    chk("R6 read data 1", int'(rlog[1]), int'(rdmem[1]));
    chk("R6 last nack", mnack_cnt, 1);
    reg_w(5, 3);
  endtask

  task automatic t_multi();
    int s;
    launch(8'hA0, 1, 8'h20, 2);
    wait_done(s);
    chk("R5 stop between starts", n_start, 2);
    chk("R5 stop between stops", n_stop, 2);
    chk("R5 bytes", wcnt, 4);
    reg_w(5, 3);
    launch(8'hA0, 1, 8'h22, 3);
    wait_done(s);
    chk("R5 rstart starts", n_start, 3);
    chk("R5 rstart stops", n_stop, 1);
    reg_w(5, 3);
    launch(8'hA0, 1, 8'h20, 0);
    wait_done(s);
    chk("R5 zero count starts", n_start, 1);
    chk("R5 zero count done", s, 1);
    reg_w(5, 3);
  endtask

  task automatic t_nack();
    int s;
    reg_w(6, 2);
    launch(8'h60, 2, 8'h20, 1);
    wait_done(s);
    chk("R7 both status bits", s, 3);
    chk("R7 no data fetched", txi, 0);
    chk("R7 stop issued", n_stop, 1);
    chk("R10 irq on ackerr mask", int'(irq), 1);
    reg_w(5, 2);
    reg_r(5, s);
    chk("R9 partial clear", s, 1);
    reg_w(5, 0);
    reg_r(5, s);
    chk("R9 zero write keeps", s, 1);
    reg_w(5, 1);
    launch(8'h60, 2, 8'h00, 1);
    wait_done(s);
    chk("R8 nack ignored status", s, 1);
    chk("R8 all bytes sent", txi, 2);
    reg_w(5, 3);
  endtask

  task automatic t_mask();
    int s;
    reg_w(6, 0);
    launch(8'hA0, 1, 8'h20, 1);
    wait_done(s);
    @(negedge clk);
    chk("R10 masked done", s, 1);
    chk("R10 irq stays low", int'(irq), 0);
    reg_w(5, 3);
  endtask

  task automatic t_srst();
    int s;
    launch(8'hA0, 4, 8'h20, 1);
    repeat (120) @(negedge clk);
    reg_w(7, 1);
    chk("R11 scl released", int'(scl_oe), 0);
    chk("R11 sda released", int'(sda_oe), 0);
    repeat (1500) @(negedge clk);
    reg_r(5, s);
    chk("R11 no done", s, 0);
    launch(8'hA0, 1, 8'h20, 1);
    wait_done(s);
    chk("R11 restart works", s, 1);
    chk("R11 restart byte", int'(wlog[1]), int'(txmem[0]));
    reg_w(5, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      txmem[i] = 8'(8'h3C + i * 8'h29);
      rdmem[i] = 8'(8'hC5 ^ (i * 8'h17));
    end
    clear_logs();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_combined();
    t_multi();
    t_nack();
    t_mask();
    t_srst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule